// File: doc/BRIEF.md
# Data EEPROM Control Register Interface

This block sits on a simple CPU register bus and controls a small nonvolatile data memory. Software sees four byte-wide registers: an address register, a data register, a control register and a key register. Software starts a read or a write by setting a bit in the control register. Hardware clears that bit when the operation is finished. A read finishes in one cycle. A write takes a programmable number of cycles, set by `WR_CYCLES`. A counter models that time, and the memory array is updated when the counter runs out.

Writes are protected in two ways. The enable bit must already be 1. The two bus writes just before the start request must put `0x55` and then `0xAA` into the key register. When a write finishes, a done flag is raised and stays set until software clears it.

The block has two reset inputs. Power-on reset clears every register. Warm reset aborts a write that is in progress and records the abort in an error bit. It keeps the address, the data and the memory contents, so software can retry the write.

Top module: `nvm_ctl`

## Requirements
- R1: The control register is read with `bus_sel`=2. Its bits are: bit0 read busy, bit1 write busy, bit2 write enable, bit3 write error, bit4 done. Bits 7:5 always read 0. Write enable and write error are read/write. Writing 1 to bit4 does not set it.
- R2: `bus_sel` selects 0 = address, 1 = data, 2 = control, 3 = key. The address and data registers read back what was written. The key register always reads `0x00`.
- R3: Software cannot clear the read or write busy bit. Writing 0 to bit0 or bit1 has no effect on them.
- R4: Writing 1 to bit0 while idle sets it for exactly one cycle. On the next clock the data register is loaded from the memory at the address, and bit0 reads 0.
- R5: A write request (bit1 = 1) is accepted only if all of these hold: the enable bit is already 1; the two bus writes just before were `0x55` and then `0xAA` to the key register; no write is in progress. Any other bus write between those steps cancels the sequence. A rejected request leaves the memory, bit1 and the done flag unchanged.
- R6: After an accepted write, bit1 reads 1 for exactly `WR_CYCLES` cycles. Then the data register value is stored at the address, bit1 and bit3 read 0, and the done flag is set.
- R7: While a write is in progress, these bus writes are ignored: new read requests, new write requests, and writes to the address and data registers.
- R8: The done flag (bit4, also driven on `done_irq`) stays 1 until a control write has bit4 = 0. If that clear falls in the same cycle as a write completion, the flag ends up 1.
- R9: Warm reset during a write aborts it, so the memory is unchanged. It sets bit3 and clears bits 0, 1 and 2. The address, the data and the done flag are kept.
- R10: Warm reset while no write is in progress leaves bit3 unchanged. It keeps the address, the data and the done flag.
- R11: Power-on reset clears the address, the data, all control bits and `done_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data of the selected register |
| done_irq | output | 1 | Write-done flag |

## Verification
Two events can land on the same clock edge: the end of a write, which sets the done flag, and a software control write that clears the same flag. The bench provokes this by counting cycles from the accepted start request. It places a control write with bit4 = 0 exactly on the completion edge. The bench then passes only if the flag and `done_irq` read 1 and the stored byte reads back correctly. A second pairing is also exercised: a warm reset that arrives in the middle of the busy window. For this case the bench checks the error bit, the preserved address and data, and the memory left unchanged.

// File: rtl/nvm_ctl.sv
module nvm_ctl #(
  parameter int ADDR_W = 8,
  parameter int WR_CYCLES = 16,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst_n,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       done_irq
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [7:0] mem [DEPTH];
  logic [7:0] addr_q, data_q;
  logic       rd_q, busy_q, wen_q, werr_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [1:0] ulk_q;

  logic ctl_wr, rd_go, wr_go, fin, key_a, key_b;
  assign ctl_wr = bus_we && bus_sel == 2'd2;
  assign key_a  = bus_we && bus_sel == 2'd3 && bus_wdata == KEY_A;
  assign key_b  = bus_we && bus_sel == 2'd3 && bus_wdata == KEY_B;
  assign fin    = busy_q && cnt_q == '0;
  assign rd_go  = ctl_wr && bus_wdata[0] && !busy_q && !rd_q;
  assign wr_go  = ctl_wr && bus_wdata[1] && !busy_q && wen_q && ulk_q == 2'd2;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      addr_q <= '0; data_q <= '0; rd_q <= 1'b0; busy_q <= 1'b0;
      wen_q <= 1'b0; werr_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0; ulk_q <= '0;
    end else if (!warm_rst_n) begin
      rd_q <= 1'b0; busy_q <= 1'b0; wen_q <= 1'b0; cnt_q <= '0; ulk_q <= '0;
      if (busy_q) werr_q <= 1'b1;
    end else begin
      if (bus_we)
        ulk_q <= key_a ? 2'd1 : (key_b && ulk_q == 2'd1) ? 2'd2 : 2'd0;
      if (bus_we && bus_sel == 2'd0 && !busy_q) addr_q <= bus_wdata;
      if (rd_q) data_q <= mem[addr_q[ADDR_W-1:0]];
      else if (bus_we && bus_sel == 2'd1 && !busy_q) data_q <= bus_wdata;
      rd_q <= rd_go;
      if (ctl_wr) begin
        wen_q  <= bus_wdata[2];
        werr_q <= bus_wdata[3];
        if (!bus_wdata[4]) done_q <= 1'b0;
      end
      if (wr_go) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(WR_CYCLES - 1);
      end else if (fin) begin
        busy_q <= 1'b0;
        werr_q <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (por_n && warm_rst_n && fin) mem[addr_q[ADDR_W-1:0]] <= data_q;

  always_comb begin
    case (bus_sel)
      2'd0:    bus_rdata = addr_q;
      2'd1:    bus_rdata = data_q;
      2'd2:    bus_rdata = {3'b000, done_q, werr_q, wen_q, busy_q, rd_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign done_irq = done_q;
endmodule

// File: rtl/nvm_ctl_chk.sv
module nvm_ctl_chk #(
  parameter int WR_CYCLES = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       warm_rst_n,
  input logic [1:0] bus_sel,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       done_irq,
  input logic       rd_q,
  input logic       busy_q,
  input logic       werr_q,
  input logic [7:0] addr_q,
  input logic [7:0] data_q
);
  logic [15:0] run_q;
  always_ff @(posedge clk)
    if (!por_n || !warm_rst_n) run_q <= '0;
    else run_q <= busy_q ? run_q + 16'd1 : 16'd0;

  assert_ctl_upper_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
    (bus_sel == 2'd2) |-> (bus_rdata[7:5] == 3'b000));

  assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_sel == 2'd3) |-> (bus_rdata == 8'h00));

  assert_rd_one_cycle_R4: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    rd_q |=> !rd_q);

  assert_wr_duration_R6: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    $rose(done_irq) |-> (run_q == 16'(WR_CYCLES)));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!por_n)
    (done_irq && !(warm_rst_n && bus_we && bus_sel == 2'd2 && !bus_wdata[4])) |=> done_irq);

  assert_abort_sets_err_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && busy_q) |=> werr_q);

  assert_warm_keeps_regs_R9: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> ($stable(addr_q) && $stable(data_q)));
endmodule

bind nvm_ctl nvm_ctl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .bus_sel(bus_sel),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .done_irq(done_irq), .rd_q(rd_q), .busy_q(busy_q), .werr_q(werr_q),
  .addr_q(addr_q), .data_q(data_q)
);

// File: tb/test_nvm_ctl.sv
`timescale 1ns/1ps
module test_nvm_ctl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst_n = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       done_irq;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  nvm_ctl #(.ADDR_W(8), .WR_CYCLES(16)) i_nvm_ctl (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_irq(done_irq)
  );

  // {write sel, write data, read sel, expected, requirement number}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 8'h3C, 2'd0, 8'h3C, 4'd2},
    {2'd1, 8'hA5, 2'd1, 8'hA5, 4'd2},
    {2'd3, 8'h55, 2'd3, 8'h00, 4'd2},
    {2'd2, 8'hE4, 2'd2, 8'h04, 4'd1},
    {2'd2, 8'h0C, 2'd2, 8'h0C, 4'd1},
    {2'd2, 8'h06, 2'd2, 8'h04, 4'd5},
    {2'd2, 8'h10, 2'd2, 8'h00, 4'd1},
    {2'd0, 8'hC3, 2'd0, 8'hC3, 4'd2}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [7:0] exp);
    bus_sel = s;
    #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic unlock();
    bus_wr(2'd3, 8'h55);
    bus_wr(2'd3, 8'hAA);
  endtask

  task automatic warm_pulse();
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    rd_chk("R11 addr after por", 2'd0, 8'h00);
    rd_chk("R11 ctrl after por", 2'd2, 8'h00);
    chk("R11 irq after por", {7'd0, done_irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i][23:22], VEC[i][21:14]);
      rd_chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][13:12], VEC[i][11:4]);
    end

    // full write with ignored requests during busy
    bus_wr(2'd0, 8'h10); bus_wr(2'd1, 8'h5A); bus_wr(2'd2, 8'h04);
    unlock();
    bus_wr(2'd2, 8'h06);
    rd_chk("R6 busy after accept", 2'd2, 8'h06);
    bus_wr(2'd2, 8'h04);
    rd_chk("R3 busy not clearable", 2'd2, 8'h06);
    bus_wr(2'd0, 8'h77);
    rd_chk("R7 addr locked", 2'd0, 8'h10);
    bus_wr(2'd2, 8'h05);
    rd_chk("R7 read request ignored", 2'd2, 8'h06);
    rd_chk("R7 data untouched", 2'd1, 8'h5A);
    repeat (12) @(negedge clk);
    rd_chk("R6 busy last cycle", 2'd2, 8'h06);
    @(negedge clk);
    rd_chk("R6 done after window", 2'd2, 8'h14);
    chk("R6 irq out", {7'd0, done_irq}, 8'h01);

    // read back
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'h15);
    rd_chk("R4 rd bit set", 2'd2, 8'h15);
    @(negedge clk);
    rd_chk("R4 data loaded", 2'd1, 8'h5A);
    rd_chk("R4 rd bit clear", 2'd2, 8'h14);
    chk("R8 irq held", {7'd0, done_irq}, 8'h01);
    bus_wr(2'd2, 8'h04);
    chk("R8 irq cleared", {7'd0, done_irq}, 8'h00);

    // gating
    bus_wr(2'd1, 8'h99); bus_wr(2'd2, 8'h00);
    unlock();
    bus_wr(2'd2, 8'h02);
    rd_chk("R5 no enable", 2'd2, 8'h00);
    bus_wr(2'd2, 8'h04); bus_wr(2'd3, 8'h55); bus_wr(2'd1, 8'h99); bus_wr(2'd3, 8'hAA);
    bus_wr(2'd2, 8'h06);
    rd_chk("R5 broken sequence", 2'd2, 8'h04);
    repeat (20) @(negedge clk);
    chk("R5 no done", {7'd0, done_irq}, 8'h00);
    bus_wr(2'd2, 8'h05);
    @(negedge clk);
    rd_chk("R5 memory unchanged", 2'd1, 8'h5A);

    // completion and software clear on the same edge
    bus_wr(2'd0, 8'h20); bus_wr(2'd1, 8'h33);
    unlock();
    bus_wr(2'd2, 8'h06);
    repeat (15) @(negedge clk);
    bus_wr(2'd2, 8'h04);
    rd_chk("R8 set wins over clear", 2'd2, 8'h14);
    chk("R8 irq on collision", {7'd0, done_irq}, 8'h01);
    bus_wr(2'd1, 8'h00); bus_wr(2'd2, 8'h15);
    @(negedge clk);
    rd_chk("R6 stored byte", 2'd1, 8'h33);

    // warm reset aborting a write
    bus_wr(2'd1, 8'h44);
    unlock();
    bus_wr(2'd2, 8'h16);
    repeat (4) @(negedge clk);
    warm_pulse();
    rd_chk("R9 ctrl after abort", 2'd2, 8'h18);
    rd_chk("R9 addr kept", 2'd0, 8'h20);
    rd_chk("R9 data kept", 2'd1, 8'h44);
    repeat (20) @(negedge clk);
    bus_wr(2'd2, 8'h11);
    @(negedge clk);
    rd_chk("R9 memory unchanged", 2'd1, 8'h33);
    rd_chk("R9 ctrl after readback", 2'd2, 8'h10);

    // warm reset while idle
    bus_wr(2'd2, 8'h18);
    warm_pulse();
    rd_chk("R10 error kept set", 2'd2, 8'h18);
    bus_wr(2'd2, 8'h10);
    warm_pulse();
    rd_chk("R10 error kept clear", 2'd2, 8'h10);
    rd_chk("R10 addr kept", 2'd0, 8'h20);

    // power-on reset
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rd_chk("R11 addr cleared", 2'd0, 8'h00);
    rd_chk("R11 data cleared", 2'd1, 8'h00);
    rd_chk("R11 ctrl cleared", 2'd2, 8'h00);
    chk("R11 irq cleared", {7'd0, done_irq}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired got 00 expected 01");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule